// File: doc/BRIEF.md
# MDIO Management Master

This block is the host side of a two-wire PHY management bus. A single request gives the frame style, the opcode, the 5-bit port or PHY address, the 5-bit register or device address and a 16-bit write word. The block then runs one complete serial frame. It produces the management clock by dividing the system clock. It drives the shared data line only in the phases it owns. It releases the line so the addressed PHY can answer during a read. When the frame ends it returns a one-cycle response carrying the read word and a no-response flag.

Two frame styles are supported. The classic style addresses one of 32 registers in one of 32 PHYs. The extended style uses the second 5-bit field as a device address, and its 16-bit field carries either a register address or data. An optional preamble of 32 one-bits comes before each frame and can be suppressed. The half-period of the management clock is a run-time input given in system cycles. At 125 MHz, a value of 25 keeps the clock at 2.5 MHz, and smaller values give faster clocks.

Requests use a valid/ready handshake. `req_ready` is low for as long as a frame is in progress, and a requester keeps `req_valid` and its fields steady until the handshake completes. Responses have no back-pressure: `rsp_valid` is high for exactly one cycle and must be taken in that cycle.

Top module: `mdio_master`

## Requirements
- R1: `req_ready` equals the inverse of `busy`. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `busy` then stays high without a gap until the cycle in which `rsp_valid` pulses. A request held during a frame waits and is accepted only after that frame ends.
- R2: When `cfg_nopre` is 0, the frame is preceded by 32 one-bits. When it is 1, the frame starts directly. Either way, every frame bit gets exactly one rising edge of `mdc`.
- R3: A classic frame (`req_ext`=0) is sent MSB first as start 01, then the 2-bit opcode (01 write, 10 read), then 5-bit PHY address, then 5-bit register address, then turnaround, then 16 data bits. On a write the master drives turnaround as 1 then 0.
- R4: An extended frame (`req_ext`=1) uses start 00. The opcode is 00 address, 01 write, 10 read with post-increment, or 11 read. It is followed by the 5-bit port address, then the 5-bit device address in the register slot, then turnaround, then the 16-bit address/data word.
- R5: Each half-period of `mdc` lasts `cfg_div` system cycles, and a value of 0 acts as 1. `mdc` is low whenever no frame is running.
- R6: `mdio_o` and `mdio_oe` change only while `mdc` is low, that is, at falling edges. The value driven is therefore stable around every rising edge.
- R7: On a read (classic opcode 10, extended opcodes 10 and 11), `mdio_oe` is low for both turnaround bits and all 16 data bits.
- R8: Read data is sampled on `mdc` rising edges, MSB first, and shown on `rsp_rdata` during the one-cycle `rsp_valid` pulse. For writes and address frames, `rsp_rdata` is 0.
- R9: `rsp_noresp` is 1 when the line is high at the second turnaround bit of a read, meaning no PHY pulled it low. Otherwise it is 0, and it is always 0 for non-read frames.
- R10: Out of reset and between frames, `mdio_oe` is 0, so the line idles high through the pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Management clock half-period in system cycles |
| cfg_nopre | input | 1 | Suppress the 32-bit preamble |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_ext | input | 1 | 0 classic frame, 1 extended frame |
| req_op | input | 2 | Opcode placed in the frame |
| req_phy | input | 5 | PHY or port address |
| req_dev | input | 5 | Register address (classic) or device address (extended) |
| req_wdata | input | 16 | Write data or extended address word |
| rsp_valid | output | 1 | One-cycle frame-complete pulse |
| rsp_rdata | output | 16 | Read data |
| rsp_noresp | output | 1 | No PHY drove the turnaround low |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input (resolved bus value) |

## Verification
The main sweep covers every legal opcode of both frame styles, with and without preamble, at three clock divisors. Each combination is run with three address/data patterns, where the two address fields take different values, so a swapped or misplaced field shows up in the captured bit stream. A PHY model answers reads with a word derived from the request, and a second read with the PHY silent separates the no-response path from a genuine all-ones answer. Divisor 0, a 2.5 MHz divisor, and a request held during a running frame cover the divisor clamp and back-pressure.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W  = 32;
  localparam int PRE_W    = 32;
  localparam int DATA_W   = 16;
  localparam int IDX_W    = 6;
  localparam int TA_HI    = 17;   // first turnaround bit index
  localparam int TA_LO    = 16;   // second turnaround bit index
  localparam int DATA_TOP = 15;

  localparam logic [1:0] ST_CLASSIC = 2'b01;
  localparam logic [1:0] ST_EXT     = 2'b00;
  localparam logic [1:0] TA_WRITE   = 2'b10;
  localparam logic [1:0] OPC_RD     = 2'b10;

  typedef struct packed {
    logic              ext;
    logic [1:0]        op;
    logic [4:0]        phy;
    logic [4:0]        dev;
    logic [DATA_W-1:0] wdata;
  } mgmt_req_t;

  function automatic logic op_is_read(input logic ext, input logic [1:0] op);
    return ext ? op[1] : (op == OPC_RD);
  endfunction

  function automatic logic [FRAME_W-1:0] pack_frame(input mgmt_req_t r);
    return {(r.ext ? ST_EXT : ST_CLASSIC), r.op, r.phy, r.dev, TA_WRITE, r.wdata};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic             wrap;

  assign div_eff   = (div == '0) ? DIV_W'(1) : div;
  assign wrap      = run && (cnt >= div_eff - DIV_W'(1));
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R5
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  // R5
  mdc_toggle_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdc) && $past(run)) |-> ($past(cnt) >= $past(div_eff) - DIV_W'(1)));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  mgmt_req_t         req,
  input  logic              nopre,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              req_ready,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_noresp
);
  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] frm;
  logic               rd;

  assign req_ready = !busy;
  assign mdio_o    = !busy || idx[IDX_W-1] || frm[idx[IDX_W-2:0]];
  assign mdio_oe   = busy && !(rd && (idx <= IDX_W'(TA_HI)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      idx        <= '0;
      frm        <= '0;
      rd         <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_noresp <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy       <= 1'b1;
          idx        <= nopre ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W + PRE_W - 1);
          frm        <= pack_frame(req);
          rd         <= op_is_read(req.ext, req.op);
          rsp_rdata  <= '0;
          rsp_noresp <= 1'b0;
        end
      end else begin
        if (rise_tick && rd) begin
          if (idx <= IDX_W'(DATA_TOP)) rsp_rdata <= {rsp_rdata[DATA_W-2:0], mdio_i};
          if (idx == IDX_W'(TA_LO))    rsp_noresp <= mdio_i;
        end
        if (fall_tick) begin
          if (idx == '0) begin
            busy      <= 1'b0;
            rsp_valid <= 1'b1;
          end else begin
            idx <= idx - IDX_W'(1);
          end
        end
      end
    end
  end

  // R6
  drive_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_nopre,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ext,
  input  logic [1:0]        req_op,
  input  logic [4:0]        req_phy,
  input  logic [4:0]        req_dev,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_noresp,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  mgmt_req_t req;
  logic      rise_tick;
  logic      fall_tick;

  assign req = '{ext: req_ext, op: req_op, phy: req_phy, dev: req_dev, wdata: req_wdata};

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .div       (cfg_div),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req        (req),
    .nopre      (cfg_nopre),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .mdc        (mdc),
    .mdio_i     (mdio_i),
    .req_ready  (req_ready),
    .busy       (busy),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_noresp (rsp_noresp)
  );

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  // R5
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mdc);
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic        cfg_nopre = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_ext = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [4:0]  req_phy = 5'd0;
  logic [4:0]  req_dev = 5'd0;
  logic [15:0] req_wdata = 16'd0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        rsp_noresp;
  logic        busy;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        line;
  logic        phy_oe = 1'b0;
  logic        phy_o = 1'b1;

  assign line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_master u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_nopre(cfg_nopre),
    .req_valid(req_valid), .req_ready(req_ready), .req_ext(req_ext),
    .req_op(req_op), .req_phy(req_phy), .req_dev(req_dev), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_noresp(rsp_noresp),
    .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
  );

  int checks = 0;
  int fails = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // PHY model and line monitors
  int          rises = 0;
  logic [63:0] cap = '0;
  bit          cur_read = 0;
  bit          cur_resp = 1;
  int          cur_pre = 32;
  logic [15:0] cur_pd = '0;
  int          oe_viol = 0;
  int          edge_viol = 0;
  int          hi_cnt = 0;
  int          hi_len = 0;
  logic        last_o = 1'b1;
  logic        last_oe = 1'b0;

  always @(posedge mdc) begin
    if (cur_read && (rises - cur_pre) >= 14 && mdio_oe) oe_viol++;
    cap = {cap[62:0], line};
    rises++;
  end

  always @(negedge mdc) begin
    int p;
    p = rises - cur_pre;
    if (cur_read && cur_resp && p >= 15 && p <= 31) begin
      phy_oe = 1'b1;
      phy_o  = (p == 15) ? 1'b0 : cur_pd[31 - p];
    end else begin
      phy_oe = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (mdc && (mdio_o !== last_o || mdio_oe !== last_oe)) edge_viol++;
    last_o  = mdio_o;
    last_oe = mdio_oe;
    if (mdc) hi_cnt++;
    else if (hi_cnt != 0) begin
      hi_len = hi_cnt;
      hi_cnt = 0;
    end
  end

  function automatic logic [15:0] phy_answer(input logic [4:0] phy, input logic [4:0] dev,
                                              input logic [15:0] wd);
    return wd ^ 16'h5A3C ^ {phy, dev, 6'b000000};
  endfunction

  task automatic run_txn(input bit ext, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] dev, input logic [15:0] wd, input bit resp,
                         input int d, input bit np);
    bit          rd;
    int          gap;
    int          n;
    logic [1:0]  ta;
    logic [15:0] dat;
    logic [31:0] exp;
    int          pre;
    rd  = ext ? op[1] : (op == 2'b10);
    pre = np ? 0 : 32;
    cur_read = rd; cur_resp = resp; cur_pre = pre;
    cur_pd = phy_answer(phy, dev, wd);
    rises = 0; cap = '0; oe_viol = 0; edge_viol = 0; hi_len = 0;
    @(negedge clk);
    cfg_div = 8'(d); cfg_nopre = np;
    req_ext = ext; req_op = op; req_phy = phy; req_dev = dev; req_wdata = wd;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R1", "ready while idle", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R1", "busy after accept", {63'd0, busy}, 64'd1);
    gap = 0; n = 0;
    while (!rsp_valid && n < 100000) begin
      @(negedge clk);
      n++;
      if (!busy && !rsp_valid) gap++;
    end
    chk(gap == 0, "R1", "busy gap cycles", 64'(gap), 64'd0);
    ta  = (rd && !resp) ? 2'b11 : 2'b10;
    dat = rd ? (resp ? cur_pd : 16'hFFFF) : wd;
    exp = {(ext ? 2'b00 : 2'b01), op, phy, dev, ta, dat};
    chk(rises == pre + 32, "R2", "mdc rising edges", 64'(rises), 64'(pre + 32));
    if (ext) chk(cap[31:0] == exp, "R4", "extended frame bits", {32'd0, cap[31:0]}, {32'd0, exp});
    else     chk(cap[31:0] == exp, "R3", "classic frame bits", {32'd0, cap[31:0]}, {32'd0, exp});
    if (!np) chk(cap[63:32] == 32'hFFFFFFFF, "R2", "preamble ones", {32'd0, cap[63:32]}, 64'hFFFFFFFF);
    chk(hi_len == ((d == 0) ? 1 : d), "R5", "mdc half period", 64'(hi_len), 64'((d == 0) ? 1 : d));
    chk(rsp_rdata == (rd ? dat : 16'h0), "R8", "response data", {48'd0, rsp_rdata},
        {48'd0, (rd ? dat : 16'h0)});
    chk(rsp_noresp == (rd && !resp), "R9", "no-response flag", {63'd0, rsp_noresp},
        {63'd0, (rd && !resp)});
    if (rd) chk(oe_viol == 0, "R7", "drive during read turnaround/data", 64'(oe_viol), 64'd0);
    chk(edge_viol == 0, "R6", "drive change while mdc high", 64'(edge_viol), 64'd0);
    @(negedge clk);
    chk(!mdio_oe && !busy && !mdc, "R10", "idle released",
        {61'd0, mdio_oe, busy, mdc}, 64'd0);
    chk(!rsp_valid, "R8", "response single cycle", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!mdio_oe && !busy && !mdc && !rsp_valid && req_ready, "R10", "reset state",
        {59'd0, mdio_oe, busy, mdc, rsp_valid, req_ready}, 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int np = 0; np < 2; np++)
      for (int d = 1; d <= 3; d++)
        for (int ext = 0; ext < 2; ext++)
          for (int k = 0; k < (ext ? 4 : 2); k++)
            for (int j = 0; j < 3; j++) begin
              logic [1:0]  op;
              logic [4:0]  phy;
              logic [15:0] wd;
              op  = ext ? 2'(k) : ((k == 0) ? 2'b01 : 2'b10);
              phy = 5'(j * 13 + d);
              wd  = 16'hA5C3 ^ 16'(j * 16'h1111) ^ 16'(k);
              run_txn(ext[0], op, phy, ~phy, wd, 1'b1, d, np[0]);
            end

    // boundary addresses, divisor clamp and 2.5 MHz divisor
    run_txn(1'b0, 2'b10, 5'd31, 5'd0, 16'h0000, 1'b1, 0, 1'b1);
    run_txn(1'b1, 2'b11, 5'd0, 5'd31, 16'hFFFF, 1'b1, 25, 1'b0);
    // R9 silent PHY, both styles
    run_txn(1'b0, 2'b10, 5'd7, 5'd3, 16'h1234, 1'b0, 2, 1'b1);
    run_txn(1'b1, 2'b10, 5'd9, 5'd1, 16'h4321, 1'b0, 1, 1'b0);

    // R1 back-pressure: second request held while first frame runs
    begin
      int ready_hi;
      int rsp_seen;
      int n;
      logic [31:0] expb;
      cur_read = 0; cur_pre = 0; rises = 0; cap = '0;
      ready_hi = 0; rsp_seen = 0; n = 0;
      @(negedge clk);
      cfg_div = 8'd1; cfg_nopre = 1'b1;
      req_ext = 1'b0; req_op = 2'b01; req_phy = 5'd3; req_dev = 5'd4; req_wdata = 16'h1111;
      req_valid = 1'b1;
      @(negedge clk);
      req_phy = 5'd12; req_dev = 5'd17; req_wdata = 16'hBEEF;
      while (rsp_seen == 0 && n < 10000) begin
        if (req_ready) ready_hi++;
        @(negedge clk); n++;
        if (rsp_valid) rsp_seen++;
      end
      chk(ready_hi == 0, "R1", "ready low while busy", 64'(ready_hi), 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 10000) begin
        @(negedge clk); n++;
      end
      expb = {2'b01, 2'b01, 5'd12, 5'd17, 2'b10, 16'hBEEF};
      chk(rises == 64, "R1", "two frames of edges", 64'(rises), 64'd64);
      chk(cap[31:0] == expb, "R1", "held request sent after first", {32'd0, cap[31:0]}, {32'd0, expb});
    end

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule